// File: doc/BRIEF.md
# Branch Resolution and Accuracy Unit

This block lives in the execute stage of a pipelined core. When a branch resolves, it takes the real direction and the computed target. It compares the resulting next address with the next-PC value that fetch actually used, which was carried down the pipeline alongside the instruction. If the two differ, the block raises a one-cycle flush and supplies the address on which fetch should restart. The comparison is made on the address that was followed, not on the predicted direction. A branch whose direction was predicted correctly but whose target came from a stale buffer entry is therefore still caught.

Every resolved branch raises write enables for the direction predictor and for the target buffer. This covers conditional branches, direct jumps and register-indirect jumps, whether taken or not. The block also keeps two saturating event counters: one for all resolved branches and one for branches that needed no flush. Software or a trace monitor can divide the second by the first to get prediction accuracy. A branch that matches its predicted path produces no flush, so it costs no bubble.

Top module: `branch_resolve_unit`

## Requirements
- R1: With brValid high and brTaken low, flush is high in the same cycle exactly when predNextPc differs from brPc+4.
- R2: With brValid high and brTaken high, flush is high in the same cycle exactly when predNextPc differs from brTarget, even if fetch also chose the taken direction.
- R3: flush is never high while brValid is low, whatever the other inputs are. Such a cycle leaves both counters unchanged.
- R4: While brValid is high, redirectPc equals brTarget when brTaken is high and brPc+4 when it is low.
- R5: phtUpdEn and btbUpdEn are both high in every cycle with brValid high, for taken and not-taken branches alike, and both are low otherwise.
- R6: totalCount increases by one on the clock edge that ends each cycle with brValid high.
- R7: correctCount increases by one on that edge only if flush was low in that cycle.
- R8: Both counters read zero after reset. Their width defaults to 32 bits.
- R9: A counter at its all-ones value stays there instead of wrapping to zero.
- R10: The sequential address brPc+4 wraps modulo 2^XLEN, so a not-taken branch at the highest word address expects fetch to continue at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | A branch resolves this cycle |
| brTaken | input | 1 | Resolved direction |
| brPc | input | XLEN | Address of the branch |
| brTarget | input | XLEN | Computed branch target |
| predNextPc | input | XLEN | Next address fetch followed after the branch |
| flush | output | 1 | Mispredict flush pulse |
| redirectPc | output | XLEN | Resolved next address |
| phtUpdEn | output | 1 | Direction predictor update enable |
| btbUpdEn | output | 1 | Target buffer update enable |
| totalCount | output | CNT_W | Resolved branch count |
| correctCount | output | CNT_W | Correctly predicted branch count |

## Verification
The flush decision and the redirect address are combinational, so a wrong comparison shows at the ports in the same cycle as the branch. A missing wrap of brPc+4 also shows in that cycle, as a false flush at the top of the address space. A wrong counter state appears one edge later. If a counter was steered by the wrong strobe, the correct count drifts away from the total-minus-flush figure. If saturation is missing, a counter drops from all ones to zero on the next branch. The bench uses a narrow counter width so that this edge is reached quickly.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef struct packed {
    logic flush;
    logic updPred;
    logic updBtb;
    logic incTotal;
    logic incCorrect;
  } bruStrobes_t;

endpackage

// File: rtl/bru_sat_counter.sv
module bru_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)                    cnt <= '0;
    else if (inc && cnt != MaxVal) cnt <= cnt + 1'b1;
  end

  // R9: an all-ones counter holds its value
  a_r9_hold_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == MaxVal) |=> (cnt == MaxVal));

  // R6/R7: one step at most per edge
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        brValid,
  input  logic        brTaken,
  input  logic        seqMatch,
  input  logic        tgtMatch,
  output bruStrobes_t strb
);
  logic pathMiss;

  always_comb begin
    pathMiss        = brTaken ? !tgtMatch : !seqMatch;
    strb.flush      = brValid && pathMiss;
    strb.updPred    = brValid;
    strb.updBtb     = brValid;
    strb.incTotal   = brValid;
    strb.incCorrect = brValid && !pathMiss;
  end

  // R3: no flush without a valid branch
  a_r3_flush_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |-> brValid);

  // R7: a flush and a correct-count increment are exclusive
  a_r7_flush_excludes_correct: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.flush && strb.incCorrect));
endmodule

// File: rtl/bru_datapath.sv
module bru_datapath
  import bru_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brTaken,
  input  logic [XLEN-1:0]  brPc,
  input  logic [XLEN-1:0]  brTarget,
  input  logic [XLEN-1:0]  predNextPc,
  input  bruStrobes_t      strb,
  output logic             seqMatch,
  output logic             tgtMatch,
  output logic [XLEN-1:0]  redirectPc,
  output logic [CNT_W-1:0] totalCount,
  output logic [CNT_W-1:0] correctCount
);
  localparam int NumCnt = 2;
  localparam logic [XLEN-1:0] InstBytes = XLEN'(4);

  logic [XLEN-1:0]  seqPc;
  logic [NumCnt-1:0] incVec;
  logic [CNT_W-1:0] cntVec [NumCnt];

  always_comb begin
    seqPc      = brPc + InstBytes;
    seqMatch   = (predNextPc == seqPc);
    tgtMatch   = (predNextPc == brTarget);
    redirectPc = brTaken ? brTarget : seqPc;
    incVec[0]  = strb.incTotal;
    incVec[1]  = strb.incCorrect;
  end

  for (genvar g = 0; g < NumCnt; g++) begin : gCnt
    bru_sat_counter #(.W(CNT_W)) cnt_i (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incVec[g]),
      .cnt  (cntVec[g])
    );
  end

  assign totalCount   = cntVec[0];
  assign correctCount = cntVec[1];

  // R7: correct count never exceeds total
  a_r7_correct_le_total: assert property (@(posedge clk) disable iff (!rstN)
    correctCount <= totalCount);

  // R4: flush restarts at the resolved target when taken
  a_r4_redirect_taken: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush && brTaken |-> redirectPc == brTarget);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brValid,
  input  logic             brTaken,
  input  logic [XLEN-1:0]  brPc,
  input  logic [XLEN-1:0]  brTarget,
  input  logic [XLEN-1:0]  predNextPc,
  output logic             flush,
  output logic [XLEN-1:0]  redirectPc,
  output logic             phtUpdEn,
  output logic             btbUpdEn,
  output logic [CNT_W-1:0] totalCount,
  output logic [CNT_W-1:0] correctCount
);
  bruStrobes_t strb;
  logic seqMatch;
  logic tgtMatch;

  bru_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .brValid  (brValid),
    .brTaken  (brTaken),
    .seqMatch (seqMatch),
    .tgtMatch (tgtMatch),
    .strb     (strb)
  );

  bru_datapath #(.XLEN(XLEN), .CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .brTaken      (brTaken),
    .brPc         (brPc),
    .brTarget     (brTarget),
    .predNextPc   (predNextPc),
    .strb         (strb),
    .seqMatch     (seqMatch),
    .tgtMatch     (tgtMatch),
    .redirectPc   (redirectPc),
    .totalCount   (totalCount),
    .correctCount (correctCount)
  );

  assign flush    = strb.flush;
  assign phtUpdEn = strb.updPred;
  assign btbUpdEn = strb.updBtb;

  // R2: taken branch with a wrong followed address flushes
  a_r2_taken_target_miss: assert property (@(posedge clk) disable iff (!rstN)
    brValid && brTaken && (predNextPc != brTarget) |-> flush);

  // R5: update enables track every valid branch
  a_r5_update_enables: assert property (@(posedge clk) disable iff (!rstN)
    brValid |-> phtUpdEn && btbUpdEn);

  // R6: total count moves after each valid branch
  a_r6_total_moves: assert property (@(posedge clk) disable iff (!rstN)
    brValid && (totalCount != {CNT_W{1'b1}}) |=> totalCount != $past(totalCount));
endmodule

// File: tb/branch_resolve_unit_tb_top.sv
module branch_resolve_unit_tb_top;
  localparam int XLEN  = 32;
  localparam int CNT_W = 5;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic brValid = 1'b0, brTaken = 1'b0;
  logic [XLEN-1:0] brPc = '0, brTarget = '0, predNextPc = '0;
  logic flush, phtUpdEn, btbUpdEn;
  logic [XLEN-1:0] redirectPc;
  logic [CNT_W-1:0] totalCount, correctCount;

  int checks = 0;
  int errors = 0;
  int expTotal = 0;
  int expCorrect = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brTaken(brTaken),
    .brPc(brPc), .brTarget(brTarget), .predNextPc(predNextPc),
    .flush(flush), .redirectPc(redirectPc), .phtUpdEn(phtUpdEn),
    .btbUpdEn(btbUpdEn), .totalCount(totalCount), .correctCount(correctCount)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one branch slot: drive at negedge, check combinational, then counters
  task automatic step(input bit v, input bit t, input logic [XLEN-1:0] pc,
                      input logic [XLEN-1:0] tgt, input logic [XLEN-1:0] pred,
                      input string req);
    logic [XLEN-1:0] seqPc;
    logic [XLEN-1:0] resolved;
    bit expFlush;
    @(negedge clk);
    brValid = v; brTaken = t; brPc = pc; brTarget = tgt; predNextPc = pred;
    seqPc    = pc + 32'd4;
    resolved = t ? tgt : seqPc;
    expFlush = v && (pred != resolved);
    #1;
    check({req, " flush"}, flush, expFlush);
    check("R5 pht enable", phtUpdEn, v);
    check("R5 btb enable", btbUpdEn, v);
    if (v) check("R4 redirect", redirectPc, resolved);
    if (v && expTotal < CMAX) expTotal++;
    if (v && !expFlush && expCorrect < CMAX) expCorrect++;
    @(posedge clk); #1;
    check({req, " R6 total"}, totalCount, expTotal);
    check({req, " R7 correct"}, correctCount, expCorrect);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 total reset", totalCount, 0);
    check("R8 correct reset", correctCount, 0);
    @(negedge clk); rstN = 1'b1;

    step(1, 0, 32'h100, 32'h200, 32'h104, "R1 nt correct");
    step(1, 0, 32'h100, 32'h200, 32'h200, "R1 nt mispredict");
    step(1, 1, 32'h140, 32'h80,  32'h80,  "R2 taken correct");
    step(1, 1, 32'h140, 32'h80,  32'h144, "R2 taken dir miss");
    step(1, 1, 32'h180, 32'h3C0, 32'h3A0, "R2 target miss");
    step(0, 1, 32'h180, 32'h3C0, 32'h10,  "R3 invalid");
    step(0, 0, 32'h180, 32'h3C0, 32'h0,   "R3 invalid nt");
    step(1, 0, 32'hFFFF_FFFC, 32'h40, 32'h0, "R10 wrap");
    step(1, 0, 32'hFFFF_FFFC, 32'h40, 32'h1_0000, "R10 wrap miss");
    for (int i = 0; i < 40; i++)
      step(1, i[0], 32'h400 + 32'(i * 8), 32'h800, (i % 3 == 0) ? 32'h900 : 32'h800 , "R9 sweep");
    check("R9 total saturated", totalCount, CMAX);
    step(0, 0, 32'h0, 32'h0, 32'h0, "R3 idle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule